// File: doc/BRIEF.md
# Quadrature x4 direction pulse decoder

This block turns the two square-wave channels of an incremental rotary or linear encoder into two separate one-clock pulse streams. One stream is for forward motion and one is for reverse motion. Channels A and B arrive already at logic levels. The block samples them on a system clock that runs much faster than the encoder edges. It emits one pulse for every edge on either channel, so each encoder line gives four counts. A downstream up/down counter or velocity estimator can consume the two streams directly, with no direction bit to align.

Each channel is captured in a flop and then delayed by one more flop. That gives a current and a previous sample for A and for B. The four sample bits are compared against a fixed set of codes. A sample pair in which both channels moved at once cannot be resolved. It produces no pulse and sets a sticky error flag, which only a reset clears.

Sizing example: a 2500-line encoder on a shaft turning at 3600 rpm gives 600 k decoded pulses per second. The sampling clock must be well above that edge rate so that no transition is lost.

Top module: `quad_x4_decoder`

## Requirements
- R1: While rst_ni is low, and in the first clock cycle after it rises, up_o, down_o and err_o are all 0.
- R2: On the first clock edge after reset, both the current and the previous sample are loaded from the inputs. Releasing reset with A and B at any of the four level combinations therefore produces no pulse.
- R3: Forward motion is the channel sequence (A,B) = 00 -> 10 -> 11 -> 01 -> 00. Each single-channel change along that sequence produces up_o = 1 and down_o = 0.
- R4: Reverse motion is the opposite sequence (A,B) = 00 -> 01 -> 11 -> 10 -> 00. Each single-channel change along it produces down_o = 1 and up_o = 0.
- R5: Every single edge of A or B produces exactly one pulse. This holds even when edges arrive on consecutive clock cycles, so one full encoder cycle gives four pulses.
- R6: up_o and down_o are never 1 in the same clock cycle.
- R7: A change of both A and B between two successive samples produces no pulse. It sets err_o one clock cycle after the cycle in which that sample pair is held.
- R8: Once set, err_o stays 1 whatever the inputs do, until rst_ni goes low.
- R9: An input level that is stable before a rising clock edge gives its pulse in the clock cycle that follows that edge. The pulse lasts exactly one cycle if no further edge follows.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Sampling clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| a_i | input | 1 | Encoder channel A, logic level |
| b_i | input | 1 | Encoder channel B, logic level |
| up_o | output | 1 | One-cycle pulse per forward edge |
| down_o | output | 1 | One-cycle pulse per reverse edge |
| err_o | output | 1 | Sticky flag for a simultaneous change of both channels |

## Verification
A previous-sample flop that fails to follow its current-sample flop shows up within one cycle: a lone edge then yields a pulse that lasts two or more cycles, or a second pulse of the wrong direction. A wrong entry in the code table shows up as the opposite pulse, or as no pulse, in the cycle right after the edge. A bad reset seed shows up as a pulse in the first cycle after release. A fault in the error tracker shows up on err_o one cycle after a double change, or as the flag dropping while the inputs keep moving.

// File: rtl/qdec_pkg.sv
package qdec_pkg;

  // current/previous sample of both channels
  typedef struct packed {
    logic a_cur;
    logic a_prv;
    logic b_cur;
    logic b_prv;
  } qsamp_t;

  typedef enum logic [1:0] {
    MOVE_NONE = 2'd0,
    MOVE_FWD  = 2'd1,
    MOVE_REV  = 2'd2,
    MOVE_BAD  = 2'd3
  } move_e;

  function automatic move_e classify_samp(qsamp_t s);
    move_e m;
    case ({s.a_cur, s.a_prv, s.b_cur, s.b_prv})
      4'b0001, 4'b0111, 4'b1000, 4'b1110: m = MOVE_FWD;
      4'b0010, 4'b0100, 4'b1011, 4'b1101: m = MOVE_REV;
      4'b1010, 4'b1001, 4'b0110, 4'b0101: m = MOVE_BAD;
      default:                            m = MOVE_NONE;
    endcase
    return m;
  endfunction

endpackage

// File: rtl/qdec_sampler.sv
module qdec_sampler
  import qdec_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   a_i,
  input  logic   b_i,
  output qsamp_t samp_o,
  output logic   primed_o
);

  qsamp_t samp_q;
  logic   primed_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      samp_q   <= '0;
      primed_q <= 1'b0;
    end else begin
      samp_q.a_cur <= a_i;
      samp_q.b_cur <= b_i;
      // first edge after reset seeds history from the pins too
      samp_q.a_prv <= primed_q ? samp_q.a_cur : a_i;
      samp_q.b_prv <= primed_q ? samp_q.b_cur : b_i;
      primed_q     <= 1'b1;
    end
  end

  assign samp_o   = samp_q;
  assign primed_o = primed_q;

  AST_A_HISTORY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (primed_q && $past(primed_q)) |-> (samp_q.a_prv == $past(samp_q.a_cur))); // R5
  AST_B_HISTORY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (primed_q && $past(primed_q)) |-> (samp_q.b_prv == $past(samp_q.b_cur))); // R5
  AST_SEED_MATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(primed_q) |-> (samp_q.a_cur == samp_q.a_prv && samp_q.b_cur == samp_q.b_prv)); // R2

endmodule

// File: rtl/qdec_classify.sv
module qdec_classify
  import qdec_pkg::*;
(
  input  qsamp_t samp_i,
  output logic   up_o,
  output logic   down_o,
  output logic   bad_o
);

  move_e move;

  always_comb begin
    move   = classify_samp(samp_i);
    up_o   = (move == MOVE_FWD);
    down_o = (move == MOVE_REV);
    bad_o  = (move == MOVE_BAD);
  end

  always_comb begin
    if (up_o || down_o)
      AST_ONE_CHANNEL: assert ((samp_i.a_cur ^ samp_i.a_prv) != (samp_i.b_cur ^ samp_i.b_prv)); // R5
  end

endmodule

// File: rtl/qdec_fault.sv
module qdec_fault (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic primed_i,
  input  logic bad_i,
  output logic err_o
);

  logic err_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) err_q <= 1'b0;
    else if (primed_i && bad_i) err_q <= 1'b1;
  end

  assign err_o = err_q;

  AST_ERR_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_q |=> err_q); // R8
  AST_ERR_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(err_q) |-> $past(bad_i)); // R7

endmodule

// File: rtl/quad_x4_decoder.sv
module quad_x4_decoder
  import qdec_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic a_i,
  input  logic b_i,
  output logic up_o,
  output logic down_o,
  output logic err_o
);

  qsamp_t samp;
  logic   primed;
  logic   bad;

  qdec_sampler u_sampler (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .a_i     (a_i),
    .b_i     (b_i),
    .samp_o  (samp),
    .primed_o(primed)
  );

  qdec_classify u_classify (
    .samp_i (samp),
    .up_o   (up_o),
    .down_o (down_o),
    .bad_o  (bad)
  );

  qdec_fault u_fault (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .primed_i(primed),
    .bad_i   (bad),
    .err_o   (err_o)
  );

  AST_NO_BOTH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(up_o && down_o)); // R6
  AST_QUIET_AFTER_SEED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(primed) |-> (!up_o && !down_o && !err_o)); // R2
  AST_BAD_NO_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bad |-> (!up_o && !down_o)); // R7

endmodule

// File: tb/quad_x4_decoder_tb_top.sv
module quad_x4_decoder_tb_top;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic a = 1'b0;
  logic b = 1'b0;
  logic up, down, err;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic pa = 1'b0;
  logic pb = 1'b0;

  always #10 clk = ~clk;

  quad_x4_decoder dut_i (
    .clk_i (clk),
    .rst_ni(rst_n),
    .a_i   (a),
    .b_i   (b),
    .up_o  (up),
    .down_o(down),
    .err_o (err)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int gray_pos(logic ga, logic gb);
    case ({ga, gb})
      2'b00:   return 0;
      2'b10:   return 1;
      2'b11:   return 2;
      default: return 3;
    endcase
  endfunction

  // drive one sample at negedge, check the pulse in the following cycle
  task automatic apply(input logic na, input logic nb, input string req);
    int d;
    d = (gray_pos(na, nb) - gray_pos(pa, pb) + 4) % 4;
    a = na; b = nb;
    pa = na; pb = nb;
    @(negedge clk);
    chk(req, "up_o", int'(up), (d == 1) ? 1 : 0);
    chk(req, "down_o", int'(down), (d == 3) ? 1 : 0);
    chk("R6", "up&down", int'(up & down), 0);
  endtask

  task automatic idle(input int n, input string req);
    for (int c = 0; c < n; c++) begin
      @(negedge clk);
      chk(req, "idle up_o", int'(up), 0);
      chk(req, "idle down_o", int'(down), 0);
    end
  endtask

  task automatic do_reset(input logic ra, input logic rb);
    @(negedge clk);
    rst_n = 1'b0;
    a = ra; b = rb; pa = ra; pb = rb;
    #1;
    chk("R1", "reset up_o", int'(up), 0);
    chk("R1", "reset down_o", int'(down), 0);
    chk("R1", "reset err_o", int'(err), 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "first cycle err_o", int'(err), 0);
    chk("R2", "seed up_o", int'(up), 0);
    chk("R2", "seed down_o", int'(down), 0);
    idle(2, "R2");
  endtask

  task automatic t_seed_levels();
    do_reset(1'b1, 1'b0);
    do_reset(1'b1, 1'b1);
    do_reset(1'b0, 1'b1);
    do_reset(1'b0, 1'b0);
  endtask

  task automatic t_forward();
    logic sa[4] = '{1'b1, 1'b1, 1'b0, 1'b0};
    logic sb[4] = '{1'b0, 1'b1, 1'b1, 1'b0};
    for (int r = 0; r < 2; r++)
      for (int s = 0; s < 4; s++) begin
        apply(sa[s], sb[s], "R3");
        idle(1, "R9");
      end
    chk("R7", "err_o after forward", int'(err), 0);
  endtask

  task automatic t_reverse();
    logic sa[4] = '{1'b0, 1'b1, 1'b1, 1'b0};
    logic sb[4] = '{1'b1, 1'b1, 1'b0, 1'b0};
    for (int r = 0; r < 2; r++)
      for (int s = 0; s < 4; s++) begin
        apply(sa[s], sb[s], "R4");
        idle(2, "R9");
      end
  endtask

  task automatic t_back_to_back();
    int ups = 0;
    logic sa[4] = '{1'b1, 1'b1, 1'b0, 1'b0};
    logic sb[4] = '{1'b0, 1'b1, 1'b1, 1'b0};
    for (int s = 0; s < 4; s++) begin
      apply(sa[s], sb[s], "R5");
      ups += int'(up);
    end
    chk("R5", "pulses per full cycle", ups, 4);
    apply(1'b0, 1'b1, "R5");
    apply(1'b0, 1'b0, "R5");
    apply(1'b1, 1'b0, "R5");
    apply(1'b0, 1'b0, "R5");
    idle(1, "R9");
  endtask

  task automatic t_double_change();
    a = 1'b1; b = 1'b1; pa = 1'b1; pb = 1'b1;
    @(negedge clk);
    chk("R7", "double up_o", int'(up), 0);
    chk("R7", "double down_o", int'(down), 0);
    chk("R7", "err_o same cycle", int'(err), 0);
    @(negedge clk);
    chk("R7", "err_o set", int'(err), 1);
    apply(1'b0, 1'b1, "R8");
    apply(1'b0, 1'b0, "R8");
    idle(3, "R8");
    chk("R8", "err_o held", int'(err), 1);
    do_reset(1'b0, 1'b0);
    chk("R8", "err_o cleared by reset", int'(err), 0);
  endtask

  initial begin
    #3_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    t_seed_levels();
    t_forward();
    t_reverse();
    t_back_to_back();
    t_double_change();
    t_forward();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule